// File: doc/BRIEF.md
# Bit-Serial Table-Lookup Second-Order Recursive Filter

This block computes a second-order recursive filter, y(i) = a0·x(i) + a1·x(i−1) + a2·x(i−2) − b1·y(i−1) − b2·y(i−2), without any multiplier. The five coefficients are fixed when the design is elaborated. From them a 32-entry table of every possible signed sum of coefficients is built at that time. The block then walks through the bits of the five operands, least significant bit first, one bit position per clock. At each position the five current operand bits together form the table address. A shift-add accumulator adds the selected entry and halves the running total. At the sign position it subtracts the entry instead.

Samples are two's complement fractions of FRAC+1 bits. The top bit has weight −1 and the other bits are fraction bits. A sample enters as a parallel word with a valid strobe. The result leaves as a parallel word with a one-cycle valid pulse, FRAC+1 clocks later. The result is truncated toward minus infinity to FRAC fraction bits and clipped to the representable range. It is then fed back as the newest output history, and the older input and output histories move down by one place.

Top module: `bsda_biquad`

## Requirements
- R1: After synchronous reset, out_valid is low, out_sample is zero and all four history words are zero. The first result after reset is therefore a0·x alone.
- R2: A sample is taken on a clock edge where in_valid is high and the block is either idle or in the final (sign) bit cycle of the current sample. out_valid pulses for one cycle exactly FRAC+1 edges after the taking edge. out_sample holds its value between pulses.
- R3: in_valid asserted while a sample is in progress, other than in its sign bit cycle, is ignored. Neither the pending result, its timing nor any later result changes.
- R4: Each result equals floor(2^FRAC · y(i)), the exact recursion truncated to FRAC fraction bits, when it lies inside the output range. Coefficients are integers in units of 2^−CFRAC, and b1, b2 are the values subtracted.
- R5: A result above 1 − 2^−FRAC is clipped to the code 2^FRAC − 1, and a result below −1 is clipped to the code −2^FRAC.
- R6: After each result, the input history shifts (x(i)→x(i−1)→x(i−2)) and the output history shifts (stored result→y(i−1)→y(i−2)). The stored result is the clipped, truncated word that is emitted.
- R7: With in_valid held high, the block takes one sample and emits one result every FRAC+1 cycles, with no idle cycle between samples.
- R8: The most negative input, −1.0 (only bit FRAC set), is handled through the subtracted sign-bit term and gives the correct result.
- R9: Cycles with no sample in progress leave all history words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | New sample offered this cycle |
| in_sample | input | FRAC+1 | Input sample, two's complement fraction, bit FRAC weighs −1 |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_sample | output | FRAC+1 | Filter result, same format as the input |

## Verification
A wrong table entry, a misrouted address bit or a missed sign-bit subtraction corrupts the first result that uses the affected bit pattern. Because the output is fed back, that error then spreads into every later result. A fault in the history shifting or in the feedback path shows up one or two results later, when the corrupted word reaches the table address. A miscounted bit position moves the out_valid pulse away from FRAC+1 cycles after the taking edge, so the bench checks both the value and the exact cycle of every result.

// File: rtl/bsda_pkg.sv
`timescale 1ns/1ps
package bsda_pkg;

    // Sequencer state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    // Table address: one bit from each operand, x0 in the least significant place
    typedef struct packed {
        logic y2;
        logic y1;
        logic x2;
        logic x1;
        logic x0;
    } tap_bits_t;

    localparam int TAP_COUNT   = 5;
    localparam int TABLE_DEPTH = 1 << TAP_COUNT;

    // Signed sum of coefficients selected by one address pattern
    function automatic int da_entry(
        input int         a0,
        input int         a1,
        input int         a2,
        input int         b1,
        input int         b2,
        input logic [4:0] sel
    );
        int v;
        v = 0;
        if (sel[0]) v = v + a0;
        if (sel[1]) v = v + a1;
        if (sel[2]) v = v + a2;
        if (sel[3]) v = v - b1;
        if (sel[4]) v = v - b2;
        return v;
    endfunction

endpackage

// File: rtl/bsda_ctrl.sv
`timescale 1ns/1ps
module bsda_ctrl #(
    parameter int FRAC = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic accept,
    output logic run,
    output logic last
);
    import bsda_pkg::*;

    localparam int CW = $clog2(FRAC + 1);

    seq_state_t    state;
    logic [CW-1:0] cnt;

    assign run    = (state == ST_RUN);
    assign last   = run && (cnt == CW'(FRAC));
    assign accept = in_valid && ((state == ST_IDLE) || last);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (accept) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else if (last) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (run) begin
            cnt <= cnt + CW'(1);
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= CW'(FRAC)));  // R2
    AST_START_CLEAN: assert property (@(posedge clk) disable iff (rst)
        accept |=> (run && cnt == '0));  // R2
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (run && !last) |=> (run && cnt == $past(cnt) + CW'(1)));  // R3

endmodule

// File: rtl/bsda_rom.sv
`timescale 1ns/1ps
module bsda_rom #(
    parameter int TW = 13,
    parameter int A0 = 192,
    parameter int A1 = 128,
    parameter int A2 = 64,
    parameter int B1 = -128,
    parameter int B2 = 64
) (
    input  bsda_pkg::tap_bits_t    sel,
    output logic signed [TW-1:0]   value
);
    import bsda_pkg::*;

    logic signed [TW-1:0] tbl [TABLE_DEPTH];
    logic [TAP_COUNT-1:0] idx;

    for (genvar e = 0; e < TABLE_DEPTH; e++) begin : g_entry
        localparam int ENTRY = da_entry(A0, A1, A2, B1, B2, 5'(e));
        assign tbl[e] = TW'(ENTRY);
    end

    assign idx   = sel;
    assign value = tbl[idx];

endmodule

// File: rtl/bsda_taps.sv
`timescale 1ns/1ps
module bsda_taps #(
    parameter int FRAC = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic                run,
    input  logic                last,
    input  logic [FRAC:0]       in_sample,
    input  logic [FRAC:0]       y_new,
    output bsda_pkg::tap_bits_t sel
);
    localparam int W = FRAC + 1;

    logic [W-1:0] x0_q, x1_q, x2_q, y1_q, y2_q;

    function automatic logic [W-1:0] rotr(input logic [W-1:0] v);
        return {v[0], v[W-1:1]};
    endfunction

    // Each word rotates once per bit cycle; after W rotations it is whole again
    always_ff @(posedge clk) begin
        if (rst) begin
            x0_q <= '0;
            x1_q <= '0;
            x2_q <= '0;
            y1_q <= '0;
            y2_q <= '0;
        end else begin
            if (run) begin
                x0_q <= rotr(x0_q);
                x1_q <= rotr(x1_q);
                x2_q <= rotr(x2_q);
                y1_q <= rotr(y1_q);
                y2_q <= rotr(y2_q);
            end
            if (last) begin
                x1_q <= rotr(x0_q);
                x2_q <= rotr(x1_q);
                y1_q <= y_new;
                y2_q <= rotr(y1_q);
            end
            if (accept) begin
                x0_q <= in_sample;
            end
        end
    end

    assign sel.x0 = x0_q[0];
    assign sel.x1 = x1_q[0];
    assign sel.x2 = x2_q[0];
    assign sel.y1 = y1_q[0];
    assign sel.y2 = y2_q[0];

    AST_HIST_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(x1_q) && $stable(x2_q) && $stable(y1_q) && $stable(y2_q)));  // R9

endmodule

// File: rtl/bsda_accum.sv
`timescale 1ns/1ps
module bsda_accum #(
    parameter int FRAC  = 7,
    parameter int CFRAC = 8,
    parameter int TW    = 13
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  accept,
    input  logic                  run,
    input  logic                  last,
    input  logic signed [TW-1:0]  f_val,
    output logic [FRAC:0]         y_new,
    output logic                  out_valid,
    output logic [FRAC:0]         out_sample
);
    localparam int W     = FRAC + 1;
    localparam int ACC_W = TW + FRAC + 2;
    localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'((1 << FRAC) - 1);
    localparam logic signed [ACC_W-1:0] Y_MIN = ACC_W'(-(1 << FRAC));

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] f_ext;
    logic signed [ACC_W-1:0] step_sum;
    logic signed [ACC_W-1:0] fin;
    logic signed [ACC_W-1:0] scaled;
    logic        [W-1:0]     y_sat;

    // FRAC spare fraction bits keep every right shift exact
    assign f_ext    = ACC_W'(f_val) <<< FRAC;
    assign step_sum = acc + f_ext;
    assign fin      = acc - f_ext;
    assign scaled   = fin >>> CFRAC;

    always_comb begin
        if (scaled > Y_MAX) begin
            y_sat = Y_MAX[W-1:0];
        end else if (scaled < Y_MIN) begin
            y_sat = Y_MIN[W-1:0];
        end else begin
            y_sat = scaled[W-1:0];
        end
    end

    assign y_new = y_sat;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= last;
            if (accept) begin
                acc <= '0;
            end else if (run && !last) begin
                acc <= step_sum >>> 1;
            end
            if (last) begin
                out_sample <= y_sat;
            end
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_sample));  // R2
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);  // R7

endmodule

// File: rtl/bsda_biquad.sv
`timescale 1ns/1ps
module bsda_biquad #(
    parameter int FRAC   = 7,
    parameter int CFRAC  = 8,
    parameter int COEF_W = 10,
    parameter int A0     = 192,
    parameter int A1     = 128,
    parameter int A2     = 64,
    parameter int B1     = -128,
    parameter int B2     = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [FRAC:0] in_sample,
    output logic          out_valid,
    output logic [FRAC:0] out_sample
);
    import bsda_pkg::*;

    localparam int W  = FRAC + 1;
    localparam int TW = COEF_W + 3;
    localparam int P  = FRAC + 1;
    localparam int SW = $clog2(P + 1);

    logic                 accept, run, last;
    tap_bits_t            sel;
    logic signed [TW-1:0] f_val;
    logic [W-1:0]         y_new;

    bsda_ctrl #(.FRAC(FRAC)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .accept   (accept),
        .run      (run),
        .last     (last)
    );

    bsda_taps #(.FRAC(FRAC)) u_taps (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .run       (run),
        .last      (last),
        .in_sample (in_sample),
        .y_new     (y_new),
        .sel       (sel)
    );

    bsda_rom #(
        .TW (TW), .A0 (A0), .A1 (A1), .A2 (A2), .B1 (B1), .B2 (B2)
    ) u_rom (
        .sel   (sel),
        .value (f_val)
    );

    bsda_accum #(.FRAC(FRAC), .CFRAC(CFRAC), .TW(TW)) u_accum (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .run        (run),
        .last       (last),
        .f_val      (f_val),
        .y_new      (y_new),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    // Spacing monitor for result pulses
    logic [SW-1:0] since_out;
    logic          seen_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_out <= '0;
            seen_out  <= 1'b0;
        end else if (out_valid) begin
            since_out <= SW'(1);
            seen_out  <= 1'b1;
        end else if (since_out < SW'(P)) begin
            since_out <= since_out + SW'(1);
        end
    end

    AST_PERIOD_SPACING: assert property (@(posedge clk) disable iff (rst)
        (out_valid && seen_out) |-> (since_out >= SW'(P)));  // R7

endmodule

// File: tb/bsda_biquad_bench.sv
`timescale 1ns/1ps
module bsda_biquad_bench;

    localparam int FRAC  = 7;
    localparam int CFRAC = 8;
    localparam int A0 = 192, A1 = 128, A2 = 64, B1 = -128, B2 = 64;
    localparam int W = FRAC + 1;
    localparam int P = FRAC + 1;
    localparam int YMAX = (1 << FRAC) - 1;
    localparam int YMIN = -(1 << FRAC);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_sample = '0;
    logic         out_valid;
    logic [W-1:0] out_sample;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    int    exp_val_q[$];
    int    exp_cyc_q[$];
    string exp_tag_q[$];

    int mx1 = 0, mx2 = 0, my1 = 0, my2 = 0;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    bsda_biquad u_bsda_biquad (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_step(input int x);
        int prod, y;
        prod = A0 * x + A1 * mx1 + A2 * mx2 - B1 * my1 - B2 * my2;
        y = prod >>> CFRAC;
        if (y > YMAX) y = YMAX;
        if (y < YMIN) y = YMIN;
        mx2 = mx1; mx1 = x;
        my2 = my1; my1 = y;
        return y;
    endfunction

    // Driver: offers one sample, optionally a stray strobe mid-sample
    task automatic send(input int x, input string tag, input int glitch);
        int yexp;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = W'(x);
        @(negedge clk);
        in_valid  = 1'b0;
        yexp = model_step(x);
        exp_val_q.push_back(yexp);
        exp_cyc_q.push_back(cyc + P);
        exp_tag_q.push_back(tag);
        for (int k = 1; k <= P - 2; k++) begin
            @(negedge clk);
            in_valid  = (k == glitch);
            in_sample = (k == glitch) ? W'(8'h5A) : '0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_val_q.size() == 0) begin
                check(1'b0, "R2 unexpected result", int'($signed(out_sample)), 0);
            end else begin
                int    ev, ec;
                string et;
                ev = exp_val_q.pop_front();
                ec = exp_cyc_q.pop_front();
                et = exp_tag_q.pop_front();
                check(int'($signed(out_sample)) == ev, et, int'($signed(out_sample)), ev);
                check(cyc == ec, "R2 R7 result cycle", cyc, ec);
            end
        end
    end

    initial begin
        #(20 * 150000);
        check(1'b0, "watchdog expired", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(out_sample == '0, "R1 out_sample in reset", int'($signed(out_sample)), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

        send(64, "R1 first result a0*x", 0);
        send(0, "R6 x history", 0);
        send(0, "R6 x2 history", 0);
        send(0, "R6 y feedback", 0);
        send(-128, "R8 minus one input", 0);
        send(0, "R8 minus one in history", 0);
        send(127, "R4 largest input", 0);
        send(-37, "R4 odd negative", 0);
        idle(13);
        send(21, "R9 after idle gap", 0);
        send(-50, "R3 stray strobe ignored", 2);
        send(33, "R3 result after stray strobe", 0);
        idle(4);
        // R7 back-to-back, driving into R5 positive clipping
        for (int i = 0; i < 10; i++) send(115, "R5 R7 positive clip", 0);
        for (int i = 0; i < 10; i++) send(-128, "R5 R7 negative clip", 0);
        for (int i = 0; i < 6; i++) send(0, "R6 recovery from clip", 0);
        lfsr = 16'hACE1;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(int'(lfsr[7:0]) - 128, "R4 mixed pattern", 0);
        end
        idle(3 * P);
        check(exp_val_q.size() == 0, "R2 missing results", exp_val_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule